// File: doc/BRIEF.md
# Dual-Clock FIFO with Skew-Windowed, Latent Flag Updates

This block is a first-in first-out word buffer placed between two unrelated clock domains. A producer pushes words on the write clock and a consumer pulls them on the read clock. Each side has its own enable and its own active-low reset. The read domain reports an empty flag and a programmable almost-empty flag. The write domain reports a full flag, a programmable almost-full flag and a half-full flag. Every flag is a register that is refreshed on each edge of its own clock.

Each side sees the other side's pointer only through a two-stage Gray-code synchroniser. A write made shortly before a read edge is therefore not counted by that edge: the buffer still looks empty to it. The read side also leaves the empty state in two steps. The edge that first sees a new word only clears the empty flag; this is the latent cycle. It does not pop, whatever the read enable is, so the word is delivered by a later enabled read. Reads while empty and writes while full are dropped.

A threshold register sets both almost flags. Each domain loads it from a configuration input while its reset is held. A zero value selects one eighth of the depth.

Top module: `skew_fifo`

## Requirements
- R1: Words come out in the order they were accepted. An enabled read whose edge sees `rd_empty` low puts the next word on `rd_data` after that edge. With no enabled read, `rd_data` holds. Once both sides have been idle for eight edges of each clock, `rd_empty` is high exactly when the buffer holds no word.
- R2: An enabled read at an edge that sees `rd_empty` high is ignored. `rd_data` does not change and no word is removed.
- R3: While reset and just after it: `rd_empty`=1, `wr_full`=0, `rd_data`=0, `wr_half`=0, `rd_almost`=1 and `wr_almost`=0.
- R4: A write into an empty buffer is not recognised by the first two read-clock edges after the write edge. `rd_empty` stays high through both of them.
- R5: The read edge on which `rd_empty` falls is a latent cycle. It removes no word and leaves `rd_data` unchanged, whatever `rd_en` is. The word is delivered by a later enabled read.
- R6: `wr_full` is high when the write-side count equals the depth (2^AW). A write at an edge that sees `wr_full` high is dropped and does not advance the write pointer.
- R7: After the sides are idle, `wr_half` is high exactly when the count is greater than half the depth.
- R8: After the sides are idle, `rd_almost` is high exactly when count <= OFF, and `wr_almost` is high exactly when count >= depth - OFF. Because OFF > 0, `rd_almost` is high whenever `rd_empty` is high, and `wr_almost` is high whenever `wr_full` is high.
- R9: OFF is taken from `cfg_offset` while reset is held. A value of 0 selects depth/8; any other value is used as given.
- R10: The pointers crossing between domains are Gray coded. Each changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low, asynchronous |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | Full flag, write domain |
| wr_half | output | 1 | More than half full, write domain |
| wr_almost | output | 1 | Almost-full flag, write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Registered output word |
| rd_empty | output | 1 | Empty flag, read domain |
| rd_almost | output | 1 | Almost-empty flag, read domain |
| cfg_offset | input | AW | Almost-flag threshold; sampled during reset, 0 selects depth/8 |

## Verification
The assertions assume that `cfg_offset` is steady while reset is held, so OFF is never zero and never exceeds the depth. They also assume that the two clocks never have coincident edges. The bench changes `cfg_offset` only inside its reset task. It drives inputs on falling edges and runs the read clock on a phase offset, which keeps its edges apart from the write clock's. Random traffic runs at several enable densities, so the buffer reaches both full and empty and the read enable is exercised while empty.

// File: rtl/skew_fifo_pkg.sv
`timescale 1ns/1ps
package skew_fifo_pkg;

  function automatic logic [31:0] to_gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  function automatic int unsigned pick_offset(int unsigned cfg, int unsigned depth);
    int unsigned d8;
    d8 = (depth / 8 == 0) ? 1 : depth / 8;
    return (cfg == 0) ? d8 : cfg;
  endfunction

endpackage

// File: rtl/skew_fifo_sync.sv
`timescale 1ns/1ps
module skew_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[i] <= '0;
          else        stage[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[i] <= '0;
          else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/skew_fifo_ram.sv
`timescale 1ns/1ps
module skew_fifo_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk)
    if (we) mem[waddr] <= wdata;

  assign rword = mem[raddr];
endmodule

// File: rtl/skew_fifo_wside.sv
`timescale 1ns/1ps
module skew_fifo_wside
  import skew_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] cfg,
  input  logic [AW:0]   rgray_s,
  output logic          accept,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wptr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          half,
  output logic          almost
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  logic [PW-1:0] rbin, nxt, cnt_nxt, off_q, lim;

  assign rbin    = PW'(from_gray(32'(rgray_s)));
  assign accept  = en && !full;
  assign nxt     = wptr + PW'(accept);
  assign cnt_nxt = nxt - rbin;
  assign lim     = DEPTH_P - off_q;
  assign waddr   = wptr[AW-1:0];

  always_ff @(posedge clk)
    if (!rst_n) off_q <= PW'(pick_offset(32'(cfg), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      wgray  <= '0;
      full   <= 1'b0;
      half   <= 1'b0;
      almost <= 1'b0;
    end else begin
      wptr   <= nxt;
      wgray  <= PW'(to_gray(32'(nxt)));
      full   <= (cnt_nxt == DEPTH_P);
      half   <= (cnt_nxt > HALF_P);
      almost <= (cnt_nxt >= lim);
    end
  end
endmodule

// File: rtl/skew_fifo_rside.sv
`timescale 1ns/1ps
module skew_fifo_rside
  import skew_fifo_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] cfg,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] rword,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rptr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] data,
  output logic          empty,
  output logic          almost
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, nxt, cnt_nxt, off_q;

  assign wbin    = PW'(from_gray(32'(wgray_s)));
  // An edge that finds the flag set only refreshes it: no word leaves.
  assign pop     = en && !empty;
  assign nxt     = rptr + PW'(pop);
  assign cnt_nxt = wbin - nxt;
  assign raddr   = rptr[AW-1:0];

  always_ff @(posedge clk)
    if (!rst_n) off_q <= PW'(pick_offset(32'(cfg), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      data   <= '0;
      empty  <= 1'b1;
      almost <= 1'b1;
    end else begin
      rptr   <= nxt;
      rgray  <= PW'(to_gray(32'(nxt)));
      if (pop) data <= rword;
      empty  <= (cnt_nxt == '0);
      almost <= (cnt_nxt <= off_q);
    end
  end
endmodule

// File: rtl/skew_fifo.sv
`timescale 1ns/1ps
module skew_fifo #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_half,
  output logic          wr_almost,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_almost,
  input  logic [AW-1:0] cfg_offset
);
  localparam int PW = AW + 1;

  // Named internal events, brought out for the checker
  logic          wr_accept, rd_pop;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_ptr_bin, rd_ptr_bin, wr_gray, rd_gray;
  logic [PW-1:0] wr_gray_at_rd, rd_gray_at_wr;
  logic [DW-1:0] ram_word;

  skew_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(wr_accept), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rword(ram_word)
  );

  skew_fifo_sync #(.W(PW), .STAGES(2)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_at_rd)
  );

  skew_fifo_sync #(.W(PW), .STAGES(2)) u_sync_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_at_wr)
  );

  skew_fifo_wside #(.AW(AW)) u_wside (
    .clk(wr_clk), .rst_n(wr_rst_n), .en(wr_en), .cfg(cfg_offset),
    .rgray_s(rd_gray_at_wr), .accept(wr_accept), .waddr(wr_addr),
    .wptr(wr_ptr_bin), .wgray(wr_gray), .full(wr_full), .half(wr_half),
    .almost(wr_almost)
  );

  skew_fifo_rside #(.DW(DW), .AW(AW)) u_rside (
    .clk(rd_clk), .rst_n(rd_rst_n), .en(rd_en), .cfg(cfg_offset),
    .wgray_s(wr_gray_at_rd), .rword(ram_word), .pop(rd_pop),
    .raddr(rd_addr), .rptr(rd_ptr_bin), .rgray(rd_gray), .data(rd_data),
    .empty(rd_empty), .almost(rd_almost)
  );
endmodule

// File: rtl/skew_fifo_chk.sv
`timescale 1ns/1ps
module skew_fifo_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          wr_full,
  input logic          wr_half,
  input logic          wr_almost,
  input logic          rd_empty,
  input logic          rd_almost,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   wr_ptr_bin,
  input logic [AW:0]   rd_ptr_bin,
  input logic [AW:0]   wr_gray,
  input logic [AW:0]   rd_gray
);
  // R2: an edge that sees the buffer empty cannot move the output word
  p_empty_read_ignored_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |=> $stable(rd_data));

  // R5: the edge that clears the empty flag removes nothing
  p_latent_no_pop_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $fell(rd_empty) |-> $stable(rd_ptr_bin));

  // R8: almost-empty covers the empty state when the offset is positive
  p_almost_at_empty_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |-> rd_almost);

  // R6: no pointer advance across an edge that sees full
  p_no_overflow_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |=> $stable(wr_ptr_bin));

  // R7 and R8: a full buffer is also past half and almost full
  p_full_implies_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |-> (wr_half && wr_almost));

  // R10: single-bit steps on both crossing pointers
  p_wgray_step_r10: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  p_rgray_step_r10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind skew_fifo skew_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .wr_full(wr_full), .wr_half(wr_half), .wr_almost(wr_almost),
  .rd_empty(rd_empty), .rd_almost(rd_almost), .rd_data(rd_data),
  .wr_ptr_bin(wr_ptr_bin), .rd_ptr_bin(rd_ptr_bin),
  .wr_gray(wr_gray), .rd_gray(rd_gray)
);

// File: tb/sim_skew_fifo.sv
`timescale 1ns/1ps
module sim_skew_fifo;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] cfg_offset = '0;
  logic wr_full, wr_half, wr_almost, rd_empty, rd_almost;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0, latent_seen = 0, cur_off = 2;
  int w_prob = 0, r_prob = 0;
  bit in_rst = 1'b1, w_one = 1'b0;
  logic [DW-1:0] q [$];

  always #2.5 wr_clk = ~wr_clk;             // 200 MHz
  initial begin #1.3; forever #3.5 rd_clk = ~rd_clk; end

  skew_fifo #(.DW(DW), .AW(AW)) u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_half(wr_half), .wr_almost(wr_almost),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_almost(rd_almost), .cfg_offset(cfg_offset)
  );

  function automatic int eff_off(int cfg);
    return (cfg == 0) ? DEPTH / 8 : cfg;
  endfunction
  function automatic bit exp_half(int n);       return n > DEPTH / 2;        endfunction
  function automatic bit exp_wr_alm(int n, int o); return n >= DEPTH - o;    endfunction
  function automatic bit exp_rd_alm(int n, int o); return n <= o;            endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800us;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  // Write driver and reference queue
  initial begin
    void'($urandom(32'd4242));
    forever begin
      @(negedge wr_clk);
      if (in_rst) begin wr_en = 1'b0; continue; end
      if (w_one) begin wr_en = 1'b1; w_one = 1'b0; end
      else wr_en = (($urandom % 100) < w_prob);
      wr_data = DW'($urandom);
      if (wr_en && !wr_full) q.push_back(wr_data);
    end
  end

  // Read driver and output checks
  initial begin
    forever begin
      logic pre_e, pre_en;
      logic [DW-1:0] pre_d, exp_d;
      @(negedge rd_clk);
      if (in_rst) begin rd_en = 1'b0; continue; end
      rd_en  = (($urandom % 100) < r_prob);
      pre_e  = rd_empty;
      pre_d  = rd_data;
      pre_en = rd_en;
      @(posedge rd_clk);
      #1;
      if (in_rst) continue;
      if (pre_en && !pre_e) begin
        if (q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R1: actual pop expected no word available");
        end else begin
          exp_d = q.pop_front();
          chk("R1 read order", rd_data, exp_d);
        end
      end else if (pre_e && !rd_empty) begin
        latent_seen++;
        chk("R5 latent cycle keeps data", rd_data, pre_d);
      end else if (pre_e) begin
        chk("R2 read while empty ignored", rd_data, pre_d);
      end else begin
        chk("R1 hold without read", rd_data, pre_d);
      end
    end
  end

  task automatic do_reset(int cfg);
    in_rst = 1'b1; w_prob = 0; r_prob = 0;
    wr_rst_n = 1'b0; rd_rst_n = 1'b0; cfg_offset = AW'(cfg);
    repeat (5) @(posedge rd_clk);
    q.delete();
    cur_off = eff_off(cfg);
    #1;
    chk("R3 empty", rd_empty, 1); chk("R3 full", wr_full, 0);
    chk("R3 data", rd_data, 0);   chk("R3 half", wr_half, 0);
    chk("R3 rd_almost", rd_almost, 1); chk("R3 wr_almost", wr_almost, 0);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    in_rst = 1'b0;
    repeat (3) @(posedge rd_clk);
    #1;
    chk("R3 empty after release", rd_empty, 1);
    chk("R3 rd_almost after release", rd_almost, 1);
  endtask

  task automatic settle();
    w_prob = 0; r_prob = 0;
    repeat (8) @(posedge rd_clk);
    repeat (8) @(posedge wr_clk);
    #1;
  endtask

  task automatic check_flags(string tag);
    int n;
    n = q.size();
    chk({"R1 settled empty ", tag}, rd_empty, (n == 0));
    chk({"R6 settled full ", tag}, wr_full, (n == DEPTH));
    chk({"R7 half ", tag}, wr_half, exp_half(n));
    chk({"R8 rd_almost ", tag}, rd_almost, exp_rd_alm(n, cur_off));
    chk({"R8 wr_almost ", tag}, wr_almost, exp_wr_alm(n, cur_off));
  endtask

  task automatic write_one();
    w_one = 1'b1;
    wait (w_one == 1'b0);
    @(posedge wr_clk);
  endtask

  task automatic drain();
    r_prob = 100;
    wait (q.size() == 0);
    settle();
  endtask

  initial begin
    do_reset(0);

    // R2: reads while empty
    r_prob = 100;
    repeat (6) @(posedge rd_clk);
    settle();
    check_flags("idle");

    // R4 / R5: single write into empty while reads are requested
    r_prob = 100;
    write_one();
    @(posedge rd_clk);
    @(posedge rd_clk);
    #1;
    chk("R4 write not yet seen", rd_empty, 1);
    repeat (12) @(posedge rd_clk);
    #1;
    chk("R5 word delivered later", q.size(), 0);
    settle();

    // R9 default offset (depth/8 = 2): levels 2 and 3
    write_one(); write_one(); settle();
    chk("R9 default offset at 2", rd_almost, 1);
    check_flags("n2");
    write_one(); settle();
    chk("R9 default offset at 3", rd_almost, 0);

    // R7 half boundary
    while (q.size() < DEPTH / 2) write_one();
    settle(); check_flags("half");
    write_one(); settle(); check_flags("half+1");

    // R6 fill to full, hammer writes
    w_prob = 100;
    repeat (40) @(posedge wr_clk);
    settle();
    chk("R6 count at full", q.size(), DEPTH);
    check_flags("full");
    drain(); check_flags("drained");

    // Random traffic at several densities
    w_prob = 50; r_prob = 50; repeat (2000) @(posedge wr_clk);
    settle(); check_flags("rand50");
    w_prob = 85; r_prob = 30; repeat (2000) @(posedge wr_clk);
    settle(); check_flags("rand_wr");
    w_prob = 25; r_prob = 90; repeat (2000) @(posedge wr_clk);
    settle(); check_flags("rand_rd");
    drain();

    // R9 programmed offset 3
    do_reset(3);
    write_one(); write_one(); write_one(); settle();
    chk("R9 offset 3 at 3", rd_almost, 1);
    write_one(); settle();
    chk("R9 offset 3 at 4", rd_almost, 0);
    while (q.size() < DEPTH - 3) write_one();
    settle();
    chk("R9 wr_almost at depth-3", wr_almost, 1);
    check_flags("off3");
    w_prob = 60; r_prob = 55; repeat (2000) @(posedge wr_clk);
    settle(); check_flags("rand_off3");
    drain(); check_flags("end");

    chk("R5 latent cycles observed", (latent_seen > 0), 1);
    finish_run();
  end
endmodule